// File: doc/BRIEF.md
# Substring Partial-Match Index Finder

This block searches a short haystack string for the first place a needle string could start. Each string holds up to sixteen byte-wide characters, packed into a 128-bit word with its own length. All overlapping character pairs are compared at the same time. A priority encoder then picks the lowest offset at which every needle character that lands on a valid haystack character is equal to that character.

Needle characters that fall past the end of the haystack are unknown, and they always count as matching. A partial match at the tail of the haystack is therefore reported as a possible start. Software scanning a longer text can then move its window to that offset and search again. The block accepts one request per cycle and never stalls. The result appears in a register one cycle later.

Top module: `substr_finder`

## Requirements
- R1: While rst_ni is low, out_valid_o is 0.
- R2: in_ready_o is always 1. out_valid_o is 1 in the cycle after a cycle with in_valid_i high, and 0 after a cycle with in_valid_i low.
- R3: idx_o is the smallest offset i for which every needle character j below the needle length, with i+j below the haystack length, equals haystack character i+j. Character k of each string occupies bits [8k+7:8k].
- R4: Needle characters at haystack position i+j at or beyond the haystack length count as matching, so a match that runs off the tail of the haystack is reported.
- R5: When no offset inside the haystack qualifies, idx_o equals the haystack length. For a full 16-character haystack this is 16, and idx_o never exceeds the haystack length.
- R6: Needle bytes at or beyond the needle length, and haystack bytes at or beyond the haystack length, have no effect on idx_o.
- R7: A needle length of 0 gives idx_o = 0.
- R8: idx_o holds its last value in cycles that follow a cycle without in_valid_i.
- R9: A length input above 16 is treated as 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Request present this cycle |
| in_ready_o | output | 1 | Always high |
| hay_i | input | 128 | Haystack characters, character 0 in the low byte |
| hay_len_i | input | 5 | Haystack length, 0 to 16 |
| ndl_i | input | 128 | Needle characters, character 0 in the low byte |
| ndl_len_i | input | 5 | Needle length, 0 to 16 |
| out_valid_o | output | 1 | Result registered from last cycle's request |
| idx_o | output | 5 | Lowest possible match offset, 0 to 16 |

## Verification
The assertions assume that in_valid_i, both lengths and both data words are at defined values on every clock edge once reset is released. The bound checks compare idx_o against the clamped haystack length as it was on the edge that captured the request. The bench drives all inputs on the falling edge and holds them for exactly one rising edge. It drives lengths of 20 and 31 on purpose, so that the clamp rule is exercised rather than assumed away.

// File: rtl/substr_pkg.sv
package substr_pkg;
  localparam int unsigned NCHAR = 16;
  localparam int unsigned CW    = 8;
  localparam int unsigned DW    = NCHAR * CW;
  localparam int unsigned LENW  = $clog2(NCHAR + 1);
  localparam int unsigned IDXW  = LENW;

  typedef logic [NCHAR-1:0][NCHAR-1:0] pair_mat_t;  // [offset][needle char]
endpackage

// File: rtl/substr_match_matrix.sv
module substr_match_matrix
  import substr_pkg::*;
(
  input  logic [DW-1:0] hay_i,
  input  logic [DW-1:0] ndl_i,
  output pair_mat_t     eq_o
);
  // Only pairs that land inside the 16-char window get a comparator.
  for (genvar i = 0; i < NCHAR; i++) begin : g_off
    for (genvar j = 0; j < NCHAR; j++) begin : g_chr
      if (i + j < NCHAR) begin : g_cmp
        assign eq_o[i][j] = (hay_i[(i+j)*CW +: CW] == ndl_i[j*CW +: CW]);
      end else begin : g_out
        assign eq_o[i][j] = 1'b1;  // beyond window: unknown
      end
    end
  end
endmodule

// File: rtl/substr_offset_reduce.sv
module substr_offset_reduce
  import substr_pkg::*;
(
  input  pair_mat_t       eq_i,
  input  logic [LENW-1:0] hay_len_i,
  input  logic [LENW-1:0] ndl_len_i,
  output logic [NCHAR:0]  hit_o
);
  always_comb begin
    for (int i = 0; i < NCHAR; i++) begin
      hit_o[i] = 1'b1;
      for (int j = 0; j < NCHAR; j++) begin
        if (!((j >= int'(ndl_len_i)) || (i + j >= int'(hay_len_i)) || eq_i[i][j]))
          hit_o[i] = 1'b0;
      end
    end
    hit_o[NCHAR] = 1'b1;
  end

  // R5: offset equal to the haystack length sees only unknown chars
  always_comb begin
    a_tail_hit_r5: assert (hit_o[hay_len_i]);
  end
endmodule

// File: rtl/substr_prio_enc.sv
module substr_prio_enc
  import substr_pkg::*;
(
  input  logic [NCHAR:0]  hit_i,
  output logic [IDXW-1:0] idx_o
);
  always_comb begin
    idx_o = IDXW'(NCHAR);
    for (int k = NCHAR; k >= 0; k--) begin
      if (hit_i[k]) idx_o = IDXW'(k);
    end
  end
endmodule

// File: rtl/substr_finder.sv
module substr_finder
  import substr_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            in_valid_i,
  output logic            in_ready_o,
  input  logic [DW-1:0]   hay_i,
  input  logic [LENW-1:0] hay_len_i,
  input  logic [DW-1:0]   ndl_i,
  input  logic [LENW-1:0] ndl_len_i,
  output logic            out_valid_o,
  output logic [IDXW-1:0] idx_o
);
  logic [LENW-1:0] hlen, nlen;
  pair_mat_t       eq;
  logic [NCHAR:0]  hit;
  logic [IDXW-1:0] idx_d, idx_q;
  logic            vld_q;

  assign hlen = (int'(hay_len_i) > NCHAR) ? LENW'(NCHAR) : hay_len_i;
  assign nlen = (int'(ndl_len_i) > NCHAR) ? LENW'(NCHAR) : ndl_len_i;
  assign in_ready_o = 1'b1;

  substr_match_matrix u_mat (
    .hay_i (hay_i),
    .ndl_i (ndl_i),
    .eq_o  (eq)
  );

  substr_offset_reduce u_red (
    .eq_i      (eq),
    .hay_len_i (hlen),
    .ndl_len_i (nlen),
    .hit_o     (hit)
  );

  substr_prio_enc u_enc (
    .hit_i (hit),
    .idx_o (idx_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      idx_q <= '0;
    end else begin
      vld_q <= in_valid_i;
      if (in_valid_i) idx_q <= idx_d;
    end
  end

  assign out_valid_o = vld_q;
  assign idx_o       = idx_q;

  p_reset_idle_r1: assert property (@(posedge clk_i) !rst_ni |-> !out_valid_o);
  p_valid_next_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> out_valid_o);
  p_idle_next_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> !out_valid_o);
  p_ready_r2: assert property (@(posedge clk_i) disable iff (!rst_ni) in_ready_o);
  p_len_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> (idx_o <= $past(hlen)));
  p_empty_ndl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && ndl_len_i == '0) |=> (idx_o == '0));
  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> $stable(idx_o));
  p_range_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (int'(idx_o) <= NCHAR));
endmodule

// File: tb/substr_finder_tb.sv
module substr_finder_tb;
  localparam time CLK_PERIOD = 10ns;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic         in_ready;
  logic [127:0] hay, ndl;
  logic [4:0]   hay_len, ndl_len;
  logic         out_valid;
  logic [4:0]   idx;

  int n_chk  = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  substr_finder u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .in_valid_i  (in_valid),
    .in_ready_o  (in_ready),
    .hay_i       (hay),
    .hay_len_i   (hay_len),
    .ndl_i       (ndl),
    .ndl_len_i   (ndl_len),
    .out_valid_o (out_valid),
    .idx_o       (idx)
  );

  function automatic logic [127:0] pk(string s);
    pk = '0;
    for (int k = 0; k < s.len() && k < 16; k++) pk[k*8 +: 8] = s[k];
  endfunction

  task automatic chk_bit(string tag, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0b expected %0b", tag, act, exp);
    end
  endtask

  // drive one request for a single edge, then check the registered result
  task automatic run(string tag, string a, int al, logic [127:0] b, int bl, int exp);
    @(negedge clk);
    hay = pk(a); hay_len = 5'(al); ndl = b; ndl_len = 5'(bl); in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    n_chk++;
    if (out_valid !== 1'b1 || idx !== 5'(exp)) begin
      n_fail++;
      $display("FAIL %s: got idx=%0d valid=%0b expected idx=%0d valid=1",
               tag, idx, out_valid, exp);
    end
  endtask

  task automatic t_reset;
    rst_n = 1'b0; in_valid = 1'b0; hay = '0; ndl = '0; hay_len = '0; ndl_len = '0;
    repeat (3) @(negedge clk);
    chk_bit("R1 reset out_valid", out_valid, 1'b0);
    chk_bit("R2 ready in reset", in_ready, 1'b1);
    rst_n = 1'b1;
    @(negedge clk);
    chk_bit("R2 idle after reset", out_valid, 1'b0);
  endtask

  task automatic t_examples;
    run("R4 tail partial abcde", "abcdxyzxaaaaaabc", 16, pk("abcde"), 5, 13);
    run("R5 no match vvvv", "abcdxyzxaaaaaabc", 16, pk("vvvv"), 4, 16);
    run("R3 match at 0", "abcdxyzxaaaaaabc", 16, pk("abcd"), 4, 0);
    run("R3 mid xyz", "abcdxyzxaaaaaabc", 16, pk("xyz"), 3, 4);
    run("R3 first of repeats aab", "abcdxyzxaaaaaabc", 16, pk("aab"), 3, 12);
  endtask

  task automatic t_lengths;
    logic [127:0] junk;
    junk = pk("abcdeQQQQQQQQQQQ");
    run("R6 needle bytes past length", "abcdxyzxaaaaaabc", 16, junk, 5, 13);
    run("R6 R4 short haystack cde", "abcdef", 3, pk("cde"), 3, 2);
    run("R5 short haystack no match", "abcdef", 3, pk("zz"), 2, 3);
    run("R5 empty haystack", "abc", 0, pk("ab"), 2, 0);
    run("R7 empty needle", "abcdxyzxaaaaaabc", 16, pk("vvvv"), 0, 0);
    run("R9 haystack len 20", "abcdxyzxaaaaaabc", 20, pk("abcde"), 5, 13);
    run("R9 both len 31", "abcdxyzxaaaaaabc", 31, pk("abcdxyzxaaaaaabc"), 31, 0);
  endtask

  task automatic t_hold;
    run("R8 setup", "abcdxyzxaaaaaabc", 16, pk("xyz"), 3, 4);
    @(negedge clk);
    hay = pk("xyzz"); hay_len = 5'd4; ndl = pk("xyz"); ndl_len = 5'd3;
    repeat (3) @(negedge clk);
    chk_bit("R2 no valid without request", out_valid, 1'b0);
    n_chk++;
    if (idx !== 5'd4) begin
      n_fail++;
      $display("FAIL R8 hold: got idx=%0d expected idx=4", idx);
    end
  endtask

  task automatic t_back_to_back;
    @(negedge clk);
    hay = pk("abcdxyzxaaaaaabc"); hay_len = 5'd16; ndl = pk("xyz"); ndl_len = 5'd3;
    in_valid = 1'b1;
    @(negedge clk);
    n_chk++;
    if (out_valid !== 1'b1 || idx !== 5'd4) begin
      n_fail++;
      $display("FAIL R2 first of pair: got idx=%0d valid=%0b expected idx=4 valid=1",
               idx, out_valid);
    end
    ndl = pk("bc"); ndl_len = 5'd2;
    @(negedge clk);
    in_valid = 1'b0;
    n_chk++;
    if (out_valid !== 1'b1 || idx !== 5'd1) begin
      n_fail++;
      $display("FAIL R3 second of pair: got idx=%0d valid=%0b expected idx=1 valid=1",
               idx, out_valid);
    end
    @(negedge clk);
    chk_bit("R2 valid drops", out_valid, 1'b0);
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    t_reset();
    t_examples();
    t_lengths();
    t_hold();
    t_back_to_back();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end
endmodule